// File: doc/BRIEF.md
# Symbol-Framed Converter Stream Deframer

This block receives the serial output of a line front end's analog-to-digital converter on the DSP side. It runs on a bit clock at 48 times the symbol rate, and an asynchronous symbol-rate clock marks where each frame starts. Every symbol period carries one 48-bit frame made of two slots. Each slot holds a 16-bit word followed by 8 filler bits. The first word is the primary conversion and the second is an interpolated conversion taken later in the same period.

The symbol clock is synchronised into the bit-clock domain, and each of its rising edges realigns a frame position counter. The upper 14 bits of each word are extracted as a two's-complement sample. Each sample is presented both at its raw width and sign-extended to 16 bits, with a one-cycle valid strobe. An enable input chooses whether the interpolated sample is reported.

A sticky error flag records any framing damage:
- a filler bit that reads low
- a spare bit that reads high
- a symbol edge that arrives at any count other than a full 48 bits

The flag stays set until it is cleared by a dedicated input.

Top module: `adc_frame_rx`

## Requirements
- R1: After synchronous reset, both samples and both sign-extended samples are 0, both valids are 0 and `frame_err` is 0.
- R2: Until the first rising edge of `sym_clk` has been seen, no valid is raised and no error is flagged. Frame position 0 (the primary word's MSB) is the `ser_in` bit sampled on the second rising `clk` edge after the first `clk` edge that sees `sym_clk` high.
- R3: The primary word occupies frame positions 0..15, MSB first. `prim_sample` takes positions 0..13, and `prim_valid` is high for exactly the one cycle after the edge that samples position 15.
- R4: The interpolated word occupies positions 24..37 (sample) and 38..39 (spare). When `interp_en` is high at the edge that samples position 39, `interp_valid` pulses for one cycle with the new sample. When it is low, there is no pulse and `interp_sample` keeps its previous value.
- R5: Samples are two's complement: 0x1FFF is positive full scale, 0x0000 is mid scale and 0x2000 is negative full scale. Each `*_sext` output equals its sample with bit 13 copied into bits 15:14, so 0x2000 gives 0xE000.
- R6: A low bit at any filler position (16..23 or 40..47) sets `frame_err`.
- R7: A high bit at any spare position (14, 15, 38 or 39) sets `frame_err`.
- R8: A `sym_clk` rising edge that arrives when fewer or more than 48 bits have passed since the previous one sets `frame_err`. Edges exactly 48 bits apart never do.
- R9: `frame_err` stays set until `err_clr` is sampled high. If a new error is detected in the same cycle as the clear, the flag stays set.
- R10: If a symbol edge is missing, the position counter wraps from 47 to 0 by itself and extraction continues at the same timing. A later edge that arrives on the wrap point flags no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 48x symbol rate; data sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sym_clk | input | 1 | Asynchronous symbol-rate clock marking frame starts |
| ser_in | input | 1 | Serial converter data |
| interp_en | input | 1 | Report the interpolated sample when high |
| err_clr | input | 1 | Clears the sticky framing error |
| prim_sample | output | 14 | Primary two's-complement sample |
| prim_sext | output | 16 | Primary sample sign-extended |
| prim_valid | output | 1 | One-cycle strobe for a new primary sample |
| interp_sample | output | 14 | Interpolated two's-complement sample |
| interp_sext | output | 16 | Interpolated sample sign-extended |
| interp_valid | output | 1 | One-cycle strobe for a new interpolated sample |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The assertions assume that `sym_clk` is quiet or already settled when reset is released, and that its high and low phases each last at least the length of the synchroniser chain, so that every rising edge is seen exactly once. The stimulus drives `sym_clk` with a phase of half a symbol period and changes all inputs only on falling clock edges. It produces irregular timing only on purpose: one shortened symbol and one skipped edge. Random sample values and random interpolation enables are mixed with the full-scale, mid-scale and all-ones corners, with corrupted filler and spare bits, and with a clear that arrives in the same cycle as a new error.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  localparam int NUM_SLOTS  = 2;
  localparam int DEF_WORD_W = 16;
  localparam int DEF_SAMP_W = 14;
  localparam int DEF_FILL_W = 8;

  typedef enum logic [0:0] {
    SLOT_PRIM   = 1'b0,
    SLOT_INTERP = 1'b1
  } slot_e;
endpackage

// File: rtl/afr_sym_sync.sv
module afr_sym_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sym_async,
  output logic sym_rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], sym_async};
  end

  assign sym_rise = chain[STAGES-1] & ~chain[STAGES];

  a_r2_rise_single: assert property (@(posedge clk) disable iff (rst)
    sym_rise |=> !sym_rise);
endmodule

// File: rtl/afr_bit_counter.sv
module afr_bit_counter #(
  parameter int FRAME_LEN = 48,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_rise,
  output logic [CNT_W-1:0] pos,
  output logic             locked_now,
  output logic             edge_err
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic             locked;

  assign pos        = sym_rise ? '0 : cnt;
  assign locked_now = locked | sym_rise;
  assign edge_err   = sym_rise & locked & (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else begin
      if (locked_now) cnt <= (pos == LAST_POS) ? '0 : pos + 1'b1;
      if (sym_rise)   locked <= 1'b1;
    end
  end

  a_r10_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(FRAME_LEN));
  a_r2_idle_before_lock: assert property (@(posedge clk) disable iff (rst)
    !locked |-> cnt == '0);
endmodule

// File: rtl/afr_word_capture.sv
module afr_word_capture #(
  parameter int WORD_W   = 16,
  parameter int SAMPLE_W = 14,
  parameter int START    = 0,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_in,
  input  logic [CNT_W-1:0]    pos,
  input  logic                locked,
  input  logic                en,
  output logic [SAMPLE_W-1:0] sample,
  output logic [WORD_W-1:0]   sext,
  output logic                valid
);
  localparam int LAST  = START + WORD_W - 1;
  localparam int EXT_W = WORD_W - SAMPLE_W;

  logic [WORD_W-2:0]   sh;
  logic [WORD_W-1:0]   word;
  logic [SAMPLE_W-1:0] field;
  logic                in_word, at_last;

  assign in_word = locked && (int'(pos) >= START) && (int'(pos) <= LAST);
  assign at_last = locked && (int'(pos) == LAST);
  assign word    = {sh, ser_in};
  assign field   = word[WORD_W-1 -: SAMPLE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      sample <= '0;
      sext   <= '0;
      valid  <= 1'b0;
    end else begin
      if (in_word) sh <= word[WORD_W-2:0];
      valid <= at_last & en;
      if (at_last && en) begin
        sample <= field;
        sext   <= {{EXT_W{field[SAMPLE_W-1]}}, field};
      end
    end
  end

  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  a_r4_valid_needs_en: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(en));
  a_r2_valid_needs_lock: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(locked));
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(sample));
endmodule

// File: rtl/afr_fill_check.sv
module afr_fill_check #(
  parameter int WORD_W   = 16,
  parameter int SAMPLE_W = 14,
  parameter int FILL_W   = 8,
  parameter int SLOTS    = 2,
  parameter int CNT_W    = 6
) (
  input  logic             ser_in,
  input  logic [CNT_W-1:0] pos,
  input  logic             locked,
  output logic             bit_err
);
  localparam int SLOT_LEN = WORD_W + FILL_W;

  logic bad;

  always_comb begin
    bad = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (int'(pos) >= s*SLOT_LEN + SAMPLE_W && int'(pos) < s*SLOT_LEN + WORD_W && ser_in)
        bad = 1'b1;
      if (int'(pos) >= s*SLOT_LEN + WORD_W && int'(pos) < (s+1)*SLOT_LEN && !ser_in)
        bad = 1'b1;
    end
  end

  assign bit_err = locked & bad;
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
  import adc_frame_pkg::*;
#(
  parameter int WORD_W      = DEF_WORD_W,
  parameter int SAMPLE_W    = DEF_SAMP_W,
  parameter int FILL_W      = DEF_FILL_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sym_clk,
  input  logic                ser_in,
  input  logic                interp_en,
  input  logic                err_clr,
  output logic [SAMPLE_W-1:0] prim_sample,
  output logic [WORD_W-1:0]   prim_sext,
  output logic                prim_valid,
  output logic [SAMPLE_W-1:0] interp_sample,
  output logic [WORD_W-1:0]   interp_sext,
  output logic                interp_valid,
  output logic                frame_err
);
  localparam int SLOT_LEN  = WORD_W + FILL_W;
  localparam int FRAME_LEN = NUM_SLOTS * SLOT_LEN;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  logic             sym_rise, locked_now, edge_err, bit_err;
  logic [CNT_W-1:0] pos;

  logic [SAMPLE_W-1:0] smp  [NUM_SLOTS];
  logic [WORD_W-1:0]   sxt  [NUM_SLOTS];
  logic                vld  [NUM_SLOTS];

  afr_sym_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sym_async(sym_clk), .sym_rise(sym_rise)
  );

  afr_bit_counter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .sym_rise(sym_rise),
    .pos(pos), .locked_now(locked_now), .edge_err(edge_err)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic slot_en;
    assign slot_en = (s == int'(SLOT_PRIM)) ? 1'b1 : interp_en;

    afr_word_capture #(
      .WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W),
      .START(s * SLOT_LEN), .CNT_W(CNT_W)
    ) u_cap (
      .clk(clk), .rst(rst), .ser_in(ser_in), .pos(pos),
      .locked(locked_now), .en(slot_en),
      .sample(smp[s]), .sext(sxt[s]), .valid(vld[s])
    );
  end

  afr_fill_check #(
    .WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W), .FILL_W(FILL_W),
    .SLOTS(NUM_SLOTS), .CNT_W(CNT_W)
  ) u_chk (
    .ser_in(ser_in), .pos(pos), .locked(locked_now), .bit_err(bit_err)
  );

  always_ff @(posedge clk) begin
    if (rst)                      frame_err <= 1'b0;
    else if (bit_err || edge_err) frame_err <= 1'b1;
    else if (err_clr)             frame_err <= 1'b0;
  end

  assign prim_sample   = smp[SLOT_PRIM];
  assign prim_sext     = sxt[SLOT_PRIM];
  assign prim_valid    = vld[SLOT_PRIM];
  assign interp_sample = smp[SLOT_INTERP];
  assign interp_sext   = sxt[SLOT_INTERP];
  assign interp_valid  = vld[SLOT_INTERP];

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    frame_err && !err_clr |=> frame_err);
  a_r6_r7_bit_err_flags: assert property (@(posedge clk) disable iff (rst)
    bit_err |=> frame_err);
  a_r8_edge_err_flags: assert property (@(posedge clk) disable iff (rst)
    edge_err |=> frame_err);
  a_r3_slots_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(prim_valid && interp_valid));
endmodule

// File: tb/sim_adc_frame_rx.sv
module sim_adc_frame_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sym_clk = 1'b0, ser_in = 1'b1, interp_en = 1'b0, err_clr = 1'b0;
  logic [13:0] prim_sample, interp_sample;
  logic [15:0] prim_sext, interp_sext;
  logic        prim_valid, interp_valid, frame_err;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  logic [47:0] prev_f;
  logic [13:0] last_interp = '0;

  always #4 clk = ~clk;

  adc_frame_rx u0 (
    .clk(clk), .rst(rst), .sym_clk(sym_clk), .ser_in(ser_in),
    .interp_en(interp_en), .err_clr(err_clr),
    .prim_sample(prim_sample), .prim_sext(prim_sext), .prim_valid(prim_valid),
    .interp_sample(interp_sample), .interp_sext(interp_sext),
    .interp_valid(interp_valid), .frame_err(frame_err)
  );

  function automatic logic [47:0] mk(input logic [13:0] p, input logic [13:0] q);
    return {p, 2'b00, 8'hFF, q, 2'b00, 8'hFF};
  endfunction

  function automatic logic [15:0] sx(input logic [13:0] v);
    return {{2{v[13]}}, v};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drives one symbol; frame position p is driven at index i = p + 2
  task automatic run_symbol(input logic [47:0] f, input int len, input bit sym_on,
                            input bit ien, input int clr_at, input bit exp_err);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 18) begin
        check(prim_valid === 1'b1, "R3 prim_valid", prim_valid, 1);
        check(prim_sample === f[47:34], "R3 prim_sample", prim_sample, f[47:34]);
        check(prim_sext === sx(f[47:34]), "R5 prim_sext", prim_sext, sx(f[47:34]));
      end else if (i >= 3 && prim_valid) check(1'b0, "R3 stray prim_valid", 1, 0);
      if (i == 42) begin
        check(interp_valid === ien, "R4 interp_valid", interp_valid, ien);
        if (ien) last_interp = f[23:10];
        check(interp_sample === last_interp, "R4 interp_sample", interp_sample, last_interp);
        check(interp_sext === sx(last_interp), "R5 interp_sext", interp_sext, sx(last_interp));
      end else if (i >= 3 && interp_valid) check(1'b0, "R4 stray interp_valid", 1, 0);
      if (i == len - 1)
        check(frame_err === exp_err, "R6/R7/R8/R9 frame_err", frame_err, exp_err);
      sym_clk   = sym_on && (i < len / 2);
      ser_in    = (i < 2) ? prev_f[1 - i] : f[47 - (i - 2)];
      interp_en = ien;
      err_clr   = (i == clr_at);
    end
    prev_f = f;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] f;
    int seed;
    seed = $urandom(32'd20240611);
    prev_f = mk(14'h0, 14'h0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(prim_sample === '0 && interp_sample === '0, "R1 samples zero", {prim_sample, interp_sample}, 0);
    check(prim_sext === '0 && interp_sext === '0, "R1 sext zero", {prim_sext, interp_sext}, 0);
    check(!prim_valid && !interp_valid && !frame_err, "R1 flags low",
          {prim_valid, interp_valid, frame_err}, 0);
    // R2 no output or error before first symbol edge, even on junk data
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (prim_valid || interp_valid || frame_err)
        check(1'b0, "R2 activity before lock", {prim_valid, interp_valid, frame_err}, 0);
      ser_in = 1'($urandom);
    end
    check(!frame_err, "R2 no error before lock", frame_err, 0);

    // R3/R5 corners
    run_symbol(mk(14'h1FFF, 14'h2000), 48, 1, 1, -1, 0);
    run_symbol(mk(14'h2000, 14'h0000), 48, 1, 1, -1, 0);
    run_symbol(mk(14'h0000, 14'h3FFF), 48, 1, 1, -1, 0);
    run_symbol(mk(14'h3FFF, 14'h1FFF), 48, 1, 1, -1, 0);
    // R4 interp disabled holds value
    run_symbol(mk(14'h1234, 14'h0ABC), 48, 1, 0, -1, 0);
    // R10 missing edge: counter wraps, no error on the next edge
    run_symbol(mk(14'h0555, 14'h2AAA), 48, 0, 1, -1, 0);
    run_symbol(mk(14'h2AAA, 14'h0555), 48, 1, 1, -1, 0);
    // R6 low filler bit, then R9 clear
    f = mk(14'h0101, 14'h0202); f[31] = 1'b0;
    run_symbol(f, 48, 1, 1, -1, 1);
    run_symbol(mk(14'h0303, 14'h0404), 48, 1, 1, -1, 1);
    run_symbol(mk(14'h0505, 14'h0606), 48, 1, 1, 5, 0);
    // R7 high spare bit
    f = mk(14'h0707, 14'h0808); f[33] = 1'b1;
    run_symbol(f, 48, 1, 1, -1, 1);
    run_symbol(mk(14'h0909, 14'h0A0A), 48, 1, 1, 5, 0);
    // R7 interp spare, R6 trailing filler
    f = mk(14'h1111, 14'h2222); f[8] = 1'b1; f[2] = 1'b0;
    run_symbol(f, 48, 1, 1, -1, 1);
    run_symbol(mk(14'h0B0B, 14'h0C0C), 48, 1, 1, 5, 0);
    // R9 set wins over a clear in the same cycle (filler position 16 at index 18)
    f = mk(14'h0D0D, 14'h0E0E); f[31] = 1'b0;
    run_symbol(f, 48, 1, 1, 18, 1);
    run_symbol(mk(14'h0F0F, 14'h1010), 48, 1, 1, 5, 0);
    // R8 short symbol: error on the early edge
    run_symbol(mk(14'h1313, 14'h1414), 40, 1, 1, -1, 0);
    run_symbol(mk(14'h1515, 14'h1616), 48, 1, 1, -1, 1);
    run_symbol(mk(14'h1717, 14'h1818), 48, 1, 1, 5, 0);

    // random symbols
    for (int n = 0; n < 40; n++) begin
      run_symbol(mk(14'($urandom), 14'($urandom)), 48, 1, ($urandom % 4) != 0, -1, 0);
    end
    check(!frame_err, "R8 regular edges never flag", frame_err, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule